// File: doc/BRIEF.md
# Ones-Filling Shift Unit

This is a combinational execute-stage unit for a 64-bit RISC-V style core. It recognises the bit-manipulation shift-ones instructions and computes their result. These instructions move the first source operand left or right like a logical shift. The bit positions left empty by the shift are filled with ones instead of zeros. The shift amount comes either from the second source operand or from an immediate field in the instruction. A 32-bit word variant exists for each form; it works on the low half of the operand and sign-extends its result.

The unit looks at the instruction word together with both operands and an enable for the bit-manipulation extension. It gives back the result, a hit flag, and an illegal-instruction flag. The hit flag says that the unit claimed the instruction. The illegal flag says that the unit recognised an encoding that the current configuration does not allow. An instruction the unit does not recognise drives all three outputs low, so another execute unit can claim it. Setting the width parameter `XLEN` to 32 removes the word variants. Their encodings then raise the illegal flag.

Top module: `ones_shift_unit`

## Requirements
- R1: Shift-left-ones produces NOT((NOT rs1) << amount): rs1 moves toward bit 63 and every vacated low bit reads 1.
- R2: Shift-right-ones produces NOT((NOT rs1) >> amount): rs1 moves toward bit 0 and every vacated high bit reads 1.
- R3: Register forms are recognised by opcode 0110011 (instr[6:0]) with instr[31:25] = 0010000. instr[14:12] = 001 selects left and 101 selects right. The amount is rs2[5:0], and rs2[63:6] has no effect.
- R4: Immediate forms are recognised by opcode 0010011 with instr[31:27] = 00100 and the same funct3 choice. The amount is instr[25:20], and bit 26 is not decoded.
- R5: Word forms use opcode 0111011 for the register variant and opcode 0011011 for the immediate variant, each with instr[31:25] = 0010000. They shift only rs1[31:0] by a 5-bit amount, taken from rs2[4:0] or instr[24:20]. The right word form brings ones in at bit 31.
- R6: A word-form result is its 32-bit value sign-extended from bit 31 into bits 63:32.
- R7: While the extension enable is low, any of the eight encodings raises illegal, keeps hit low and drives the result to zero.
- R8: Any other instruction word keeps hit and illegal low and drives the result to zero.
- R9: An amount of 0 returns rs1 unchanged. An amount of 63 on the full-width left form returns ones in bits 62:0, with rs1[0] in bit 63.
- R10: Hit and illegal are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word under execution |
| rs1_i | input | 64 | First source operand (value to shift) |
| rs2_i | input | 64 | Second source operand (register-form amount) |
| bext_en_i | input | 1 | Bit-manipulation extension enable |
| result_o | output | 64 | Shift result, zero when hit is low |
| hit_o | output | 1 | Instruction recognised and executed |
| illegal_o | output | 1 | Recognised encoding not permitted |

## Verification
The bench puts junk in the upper half of rs1 and in the upper bits of rs2 for the word forms. A unit that leaked those bits would show them in the result, or would shift by the wrong amount. The right word form is checked for ones entering at bit 31. A design that shifted the full 64-bit value would instead fill from bit 63 and drag high garbage into the low word. Shifts of 0 and 63 catch off-by-one errors in the fill mask and a dropped top amount bit. Neighbouring encodings with the wrong funct3 or funct7, and the case with the extension disabled, catch a decoder that claims instructions it does not own or that reports illegal for foreign instructions.

// File: rtl/ones_shift_pkg.sv
// Shared encodings and decode record for the ones-filling shift unit.
// Assumes a standard 32-bit instruction layout (opcode in bits 6:0).
package ones_shift_pkg;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_REG_W  = 7'b0111011;
    localparam logic [6:0] OPC_IMM_W  = 7'b0011011;
    localparam logic [6:0] F7_SHONES  = 7'b0010000;
    localparam logic [4:0] F5_SHONES  = 5'b00100;
    localparam logic [2:0] F3_LEFT    = 3'b001;
    localparam logic [2:0] F3_RIGHT   = 3'b101;

    typedef struct packed {
        logic match;   // one of the eight encodings
        logic word;    // 32-bit word variant
        logic left;    // direction: 1 = left
        logic imm;     // amount comes from the instruction
    } shones_dec_t;

endpackage

// File: rtl/shones_decode.sv
// Decoder: classifies an instruction word into the shift-ones forms.
// Assumes nothing about legality; gating is done by the parent.
module shones_decode
    import ones_shift_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]  instr_i,
    output shones_dec_t  dec_o
);

    logic [6:0] opc;
    logic [6:0] f7;
    logic [2:0] f3;
    logic       f3_ok;

    assign opc   = instr_i[6:0];
    assign f7    = instr_i[31:25];
    assign f3    = instr_i[14:12];
    assign f3_ok = (f3 == F3_LEFT) || (f3 == F3_RIGHT);

    // Match the opcode/function fields and derive the form attributes.
    always_comb begin
        dec_o      = '0;
        dec_o.left = (f3 == F3_LEFT);
        case (opc)
            OPC_REG: begin
                dec_o.match = f3_ok && (f7 == F7_SHONES);
            end
            OPC_IMM: begin
                dec_o.imm   = 1'b1;
                dec_o.match = f3_ok && (instr_i[31:27] == F5_SHONES)
                              && ((XLEN > 32) || !instr_i[25]);
            end
            OPC_REG_W: begin
                dec_o.word  = 1'b1;
                dec_o.match = f3_ok && (f7 == F7_SHONES);
            end
            OPC_IMM_W: begin
                dec_o.word  = 1'b1;
                dec_o.imm   = 1'b1;
                dec_o.match = f3_ok && (f7 == F7_SHONES);
            end
            default: begin
                dec_o.match = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shones_amount.sv
// Amount selector: picks the shift count from rs2 or the immediate field,
// and limits it to 5 bits for word forms. Assumes SHW >= 5.
module shones_amount
    import ones_shift_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  shones_dec_t      dec_i,
    input  logic [31:0]      instr_i,
    input  logic [SHW-1:0]   rs2_i,
    output logic [SHW-1:0]   amt_o
);

    localparam logic [SHW-1:0] WMASK = SHW'(31);

    logic [SHW-1:0] src;

    // Choose the source field, then clip it for the word variants.
    always_comb begin
        src   = dec_i.imm ? instr_i[20 +: SHW] : rs2_i;
        amt_o = dec_i.word ? (src & WMASK) : src;
    end

endmodule

// File: rtl/shones_core.sv
// Datapath: invert, shift, invert, so vacated bits read as ones.
// The word path is generated only when WORD_EN is set (64-bit cores).
module shones_core #(
    parameter int XLEN    = 64,
    parameter bit WORD_EN = 1'b1,
    localparam int SHW    = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            left_i,
    input  logic            word_i,
    output logic [XLEN-1:0] y_o
);

    logic [XLEN-1:0] inv_full;
    logic [XLEN-1:0] full_res;

    // Full-width ones-filling shift in the selected direction.
    always_comb begin
        inv_full = ~a_i;
        full_res = left_i ? ~(inv_full << amt_i) : ~(inv_full >> amt_i);
    end

    generate
        if (WORD_EN) begin : g_word
            logic [31:0] inv_w;
            logic [31:0] word_res;
            // Low-word ones-filling shift, then sign extension to XLEN.
            always_comb begin
                inv_w    = ~a_i[31:0];
                word_res = left_i ? ~(inv_w << amt_i[4:0]) : ~(inv_w >> amt_i[4:0]);
                y_o      = word_i ? {{(XLEN-32){word_res[31]}}, word_res} : full_res;
            end
        end else begin : g_noword
            // Word forms never reach the datapath in this variant.
            assign y_o = full_res;
        end
    endgenerate

endmodule

// File: rtl/ones_shift_unit.sv
// Top: decodes the shift-ones forms, gates them by the extension enable and
// the core width, and drives result/hit/illegal. Purely combinational.
module ones_shift_unit
    import ones_shift_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  rs1_i,
    input  logic [XLEN-1:0]  rs2_i,
    input  logic             bext_en_i,
    output logic [XLEN-1:0]  result_o,
    output logic             hit_o,
    output logic             illegal_o
);

    localparam int SHW  = $clog2(XLEN);
    localparam bit RV64 = (XLEN == 64);

    shones_dec_t     dec;
    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] shifted;

    shones_decode #(.XLEN(XLEN)) u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    shones_amount #(.XLEN(XLEN)) u_amt (
        .dec_i   (dec),
        .instr_i (instr_i),
        .rs2_i   (rs2_i[SHW-1:0]),
        .amt_o   (amt)
    );

    shones_core #(.XLEN(XLEN), .WORD_EN(RV64)) u_core (
        .a_i     (rs1_i),
        .amt_i   (amt),
        .left_i  (dec.left),
        .word_i  (dec.word),
        .y_o     (shifted)
    );

    // Legality gating and zeroing of unclaimed results.
    always_comb begin
        hit_o     = dec.match && bext_en_i && (!dec.word || RV64);
        illegal_o = dec.match && !hit_o;
        result_o  = hit_o ? shifted : '0;
    end

endmodule

// File: rtl/ones_shift_unit_chk.sv
// Checker: immediate assertions on the unit's ports, bound to the top.
module ones_shift_unit_chk #(
    parameter int XLEN = 64
) (
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] rs1_i,
    input logic [XLEN-1:0] rs2_i,
    input logic            bext_en_i,
    input logic [XLEN-1:0] result_o,
    input logic            hit_o,
    input logic            illegal_o
);

    // Port-level consistency checks, evaluated whenever inputs change.
    always_comb begin
        // R10
        hit_ill_excl_chk: assert (!(hit_o && illegal_o))
            else $error("hit and illegal both high");
        // R8
        idle_zero_chk: assert (hit_o || (result_o == '0))
            else $error("result nonzero without hit");
        // R7
        ext_off_chk: assert (bext_en_i || !hit_o)
            else $error("hit while extension disabled");
        // R9
        zero_amt_chk: assert (!(hit_o && instr_i[6:0] == 7'b0110011 && rs2_i[5:0] == 6'd0)
                              || result_o == rs1_i)
            else $error("zero shift altered rs1");
        // R1
        left_fill_chk: assert (!(hit_o && instr_i[6:0] == 7'b0110011 && instr_i[14:12] == 3'b001
                                 && rs2_i[5:0] != 6'd0) || result_o[0])
            else $error("left shift did not fill bit 0 with one");
        // R6
        word_sext_chk: assert (!(hit_o && instr_i[3])
                               || (&result_o[XLEN-1:31]) || !(|result_o[XLEN-1:31]))
            else $error("word result not sign-extended");
    end

endmodule

bind ones_shift_unit ones_shift_unit_chk #(.XLEN(XLEN)) u_chk (
    .instr_i   (instr_i),
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .bext_en_i (bext_en_i),
    .result_o  (result_o),
    .hit_o     (hit_o),
    .illegal_o (illegal_o)
);

// File: tb/ones_shift_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task applies stimulus on the rising edge and
// queues the expected outputs; a monitor compares them on the falling edge.
module ones_shift_unit_test;

    typedef struct {
        logic [63:0] res;
        logic        hit;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic        en = 1'b0;
    logic [63:0] result;
    logic        hit;
    logic        illegal;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    ones_shift_unit uut (
        .instr_i   (instr),
        .rs1_i     (rs1),
        .rs2_i     (rs2),
        .bext_en_i (en),
        .result_o  (result),
        .hit_o     (hit),
        .illegal_o (illegal)
    );

    // Reference: shift then OR in a mask of ones over the vacated positions.
    function automatic logic [63:0] ref_full(logic [63:0] a, int s, bit left);
        if (left) return (a << s) | ((64'd1 << s) - 64'd1);
        return (a >> s) | ~(64'hFFFF_FFFF_FFFF_FFFF >> s);
    endfunction

    function automatic logic [63:0] ref_word(logic [63:0] a, int s, bit left);
        logic [31:0] w;
        if (left) w = (a[31:0] << s) | ((32'd1 << s) - 32'd1);
        else      w = (a[31:0] >> s) | ~(32'hFFFF_FFFF >> s);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
        return {f7, 5'd3, 5'd1, f3, 5'd2, opc};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] sh, logic b26, logic [2:0] f3);
        return {5'b00100, b26, sh, 5'd1, f3, 5'd2, 7'b0010011};
    endfunction

    function automatic logic [31:0] enc_iw(logic [4:0] sh, logic [2:0] f3);
        return {7'b0010000, sh, 5'd1, f3, 5'd2, 7'b0011011};
    endfunction

    // Driver: apply one stimulus and queue its expected outputs.
    task automatic drive(logic [31:0] i, logic [63:0] a, logic [63:0] b, logic e,
                         logic [63:0] r, logic h, logic il, string tag);
        exp_t x;
        @(posedge clk);
        instr <= i; rs1 <= a; rs2 <= b; en <= e;
        x.res = r; x.hit = h; x.ill = il; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Monitor: compare queued expectations against the ports.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_chk++;
            if (result !== x.res || hit !== x.hit || illegal !== x.ill) begin
                n_fail++;
                $display("FAIL %s: got res=%h hit=%b ill=%b, expected res=%h hit=%b ill=%b",
                         x.tag, result, hit, illegal, x.res, x.hit, x.ill);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] junk;
        junk = 64'hDEAD_BEEF_0000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 idle state after reset
        n_chk++;
        if (result !== '0 || hit !== 1'b0 || illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset: got res=%h hit=%b ill=%b, expected 0 0 0", result, hit, illegal);
        end
        rst_n = 1'b1;

        // R1 and R2 register forms
        drive(enc_r(7'b0010000, 3'b001, 7'b0110011), 64'h0000_0000_0000_00F0, 64'd4, 1,
              ref_full(64'h00F0, 4, 1), 1, 0, "R1 reg left");
        drive(enc_r(7'b0010000, 3'b101, 7'b0110011), 64'h0123_4567_89AB_CDEF, 64'd12, 1,
              ref_full(64'h0123_4567_89AB_CDEF, 12, 0), 1, 0, "R2 reg right");
        // R3 upper rs2 bits ignored (amount 5)
        drive(enc_r(7'b0010000, 3'b001, 7'b0110011), 64'h8000_0000_0000_0001, 64'hFFFF_FF00_0000_0045, 1,
              ref_full(64'h8000_0000_0000_0001, 5, 1), 1, 0, "R3 rs2 high bits");
        // R4 immediate forms, bit 26 undecoded
        drive(enc_i(6'd12, 1'b0, 3'b001), 64'h0000_0000_0000_ABCD, 64'd0, 1,
              ref_full(64'hABCD, 12, 1), 1, 0, "R4 imm left");
        drive(enc_i(6'd40, 1'b1, 3'b101), 64'h5555_0000_1234_5678, 64'd7, 1,
              ref_full(64'h5555_0000_1234_5678, 40, 0), 1, 0, "R4 imm right");
        // R5 word forms ignore rs1[63:32] and rs2[5]
        drive(enc_r(7'b0010000, 3'b001, 7'b0111011), junk | 64'h0000_1234, 64'h0000_0000_0000_0024, 1,
              ref_word(64'h1234, 4, 1), 1, 0, "R5 word reg left");
        drive(enc_r(7'b0010000, 3'b101, 7'b0111011), junk | 64'h0F00_0000, 64'd8, 1,
              64'hFFFF_FFFF_FF0F_0000, 1, 0, "R5 word reg right fill at bit 31");
        // R6 word immediate sign extension, both polarities
        drive(enc_iw(5'd4, 3'b001), junk | 64'h0000_0100, 64'd0, 1,
              64'h0000_0000_0000_100F, 1, 0, "R6 word imm positive");
        drive(enc_iw(5'd3, 3'b001), 64'h1000_0000, 64'd0, 1,
              64'hFFFF_FFFF_8000_0007, 1, 0, "R6 word imm negative");
        // R7 extension off
        drive(enc_r(7'b0010000, 3'b001, 7'b0110011), 64'h1234, 64'd3, 0,
              64'd0, 0, 1, "R7 R10 ext off reg");
        drive(enc_iw(5'd2, 3'b101), 64'h1234, 64'd0, 0,
              64'd0, 0, 1, "R7 ext off word imm");
        // R8 foreign encodings
        drive(enc_r(7'b0000000, 3'b001, 7'b0110011), 64'h1234, 64'd3, 1,
              64'd0, 0, 0, "R8 plain shift left");
        drive(enc_r(7'b0010000, 3'b010, 7'b0110011), 64'h1234, 64'd3, 1,
              64'd0, 0, 0, "R8 wrong funct3");
        drive(enc_r(7'b0010000, 3'b001, 7'b0110111), 64'h1234, 64'd3, 1,
              64'd0, 0, 0, "R8 wrong opcode");
        // R9 boundary amounts
        drive(enc_r(7'b0010000, 3'b101, 7'b0110011), 64'hA5A5_5A5A_0F0F_F0F0, 64'd0, 1,
              64'hA5A5_5A5A_0F0F_F0F0, 1, 0, "R9 zero amount");
        drive(enc_r(7'b0010000, 3'b001, 7'b0110011), 64'h0000_0000_0000_0001, 64'd63, 1,
              64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R9 amount 63 bit0 set");
        drive(enc_r(7'b0010000, 3'b001, 7'b0110011), 64'hFFFF_FFFF_FFFF_FFFE, 64'd63, 1,
              64'h7FFF_FFFF_FFFF_FFFF, 1, 0, "R9 amount 63 bit0 clear");
        drive(enc_i(6'd63, 1'b0, 3'b101), 64'h8000_0000_0000_0000, 64'd0, 1,
              64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R2 imm right 63");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule